// File: doc/BRIEF.md
# Address-Match Break Controller

This block observes the processor's bus cycles and raises a break interrupt request when a cycle hits a programmed break address. One channel is provided. The comparison can ignore a programmable number of low address bits. It is qualified by which bus master owns the cycle and by the cycle type: instruction fetch, data read or data write. A data-access hit is recorded on the cycle that makes it. An instruction-fetch hit is only remembered at fetch time. It is reported when the core signals that it is starting to execute the instruction at that address, so the request lands just before that instruction runs.

Software programs the break address and the control fields through a small register port, starts the block by clearing its stop bit, and services the request. Servicing means reading the match flag as 1 and then writing 0 to it. The bus-watch port is a pure observer, valid-only, with no ready: it never back-pressures the bus, and a cycle counts on every clock where `bus_valid` is high. The instruction-start strobe works the same way.

Top module: `brk_ctrl_top`

## Requirements
- R1: After reset, the break address, control and match flag read 0, the stop bit reads 1 and `brk_irq` is low.
- R2: With the stop bit at 0, a data cycle that matches on master, type and address sets the flag, visible on the clock after the cycle. The register selects are 0 (address), 1 (control), 2 (flag, bit 0) and 3 (stop, bit 0).
- R3: Control bits [6:5] select the cycle type: 00 fetch, 01 data read, 10 data write, 11 read or write. `bus_kind` encodes a fetch as 0, a read as 1 and a write as 2. A cycle of another type never matches.
- R4: Control bit 1 selects the master (0 = CPU, 1 = other). A data cycle whose `bus_mst` differs from it never matches.
- R5: Control bits [4:2] set the number of low address bits left out of the compare. The codes 0 to 7 leave out 0, 1, 2, 3, 4, 8, 12 and 16 bits respectively.
- R6: Control bit 0 is the interrupt enable. The flag is set on a match whatever the enable says, and `brk_irq` equals flag AND enable while the block runs.
- R7: A fetch break (type 00) needs master select 0 and a CPU fetch at the programmed address. The fetch alone leaves the flag clear. The flag is set when `instr_start` arrives with that address. `instr_start` without an earlier matching fetch sets nothing, and a fetch break with master select 1 never fires.
- R8: Writing 0 to the flag clears it only after the flag has been read as 1. A match in the same cycle as a clearing write keeps the flag set.
- R9: While the stop bit is 1, matches are ignored and `brk_irq` is held low. The registers keep their values and stay writable.
- R10: The address and control registers read back what was written, and the control register reads as a zero-extended 7-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the flag clear) |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | ADDR_W | Write data |
| reg_rdata | output | ADDR_W | Read data for `reg_sel`, combinational |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_addr | input | ADDR_W | Bus cycle address |
| bus_kind | input | 2 | Cycle type: 0 fetch, 1 read, 2 write |
| bus_mst | input | 1 | Cycle owner: 0 CPU, 1 other master |
| instr_start | input | 1 | Core begins executing an instruction |
| instr_addr | input | ADDR_W | Address of the instruction starting |
| brk_irq | output | 1 | Break interrupt request |
| brk_flag | output | 1 | Condition-match flag |

## Verification
The hardest situations to reach are a flag clear racing with a new match, and a fetch break whose report must wait for an execute strobe. The stimulus reaches the race by driving a clearing write and a matching bus cycle in the same clock, after a read has armed the clear. It splits the fetch and the instruction start into separate clocks, and checks the flag between them. It also sends instruction starts with no preceding fetch, and fetches under master select 1, to show that neither half alone fires.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2
  } bus_kind_e;

  typedef enum logic [1:0] {
    SEL_TYPE_FETCH = 2'd0,
    SEL_TYPE_READ  = 2'd1,
    SEL_TYPE_WRITE = 2'd2,
    SEL_TYPE_DATA  = 2'd3
  } type_sel_e;

  typedef struct packed {
    logic [1:0] ctype;
    logic [2:0] mask;
    logic       msel;
    logic       ie;
  } brk_ctrl_t;

  localparam int CTRL_W = 7;

  localparam logic [1:0] RSEL_ADDR = 2'd0;
  localparam logic [1:0] RSEL_CTRL = 2'd1;
  localparam logic [1:0] RSEL_FLAG = 2'd2;
  localparam logic [1:0] RSEL_STOP = 2'd3;
endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] rdata,
  input  logic              set_flag,
  output logic [ADDR_W-1:0] brk_addr,
  output brk_ctrl_t         ctrl,
  output logic              flag,
  output logic              stop
);
  logic seen_q;
  logic clr_ok;

  assign clr_ok = wr_en && (sel == RSEL_FLAG) && !wdata[0] && seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_addr <= '0;
      ctrl     <= '0;
      stop     <= 1'b1;
    end else if (wr_en) begin
      case (sel)
        RSEL_ADDR: brk_addr <= wdata;
        RSEL_CTRL: ctrl     <= brk_ctrl_t'(wdata[CTRL_W-1:0]);
        RSEL_STOP: stop     <= wdata[0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      if (set_flag)    flag <= 1'b1;
      else if (clr_ok) flag <= 1'b0;
      if (clr_ok && !set_flag)
        seen_q <= 1'b0;
      else if (rd_en && (sel == RSEL_FLAG) && flag)
        seen_q <= 1'b1;
    end
  end

  always_comb begin
    case (sel)
      RSEL_ADDR: rdata = brk_addr;
      RSEL_CTRL: rdata = {{(ADDR_W-CTRL_W){1'b0}}, ctrl};
      RSEL_FLAG: rdata = {{(ADDR_W-1){1'b0}}, flag};
      default:   rdata = {{(ADDR_W-1){1'b0}}, stop};
    endcase
  end

  // R8: the flag stays up unless software writes the flag register
  p_flag_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_en && sel == RSEL_FLAG)) |=> flag);

  // R8: a flag drop always follows a zero write to the flag register
  p_fall_by_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(wr_en && sel == RSEL_FLAG && !wdata[0]));
endmodule

// File: rtl/brk_match.sv
module brk_match
  import brk_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop,
  input  logic [ADDR_W-1:0] brk_addr,
  input  brk_ctrl_t         ctrl,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_kind,
  input  logic              bus_mst,
  input  logic              instr_start,
  input  logic [ADDR_W-1:0] instr_addr,
  output logic              set_flag
);
  logic [ADDR_W-1:0] care;
  logic              kind_ok;
  logic              fetch_hit;
  logic              data_hit;
  logic              exec_hit;
  logic              pending_q;
  int                nmask;

  always_comb begin
    case (ctrl.mask)
      3'd0:    nmask = 0;
      3'd1:    nmask = 1;
      3'd2:    nmask = 2;
      3'd3:    nmask = 3;
      3'd4:    nmask = 4;
      3'd5:    nmask = 8;
      3'd6:    nmask = 12;
      default: nmask = 16;
    endcase
    for (int i = 0; i < ADDR_W; i++) care[i] = (i >= nmask);
  end

  always_comb begin
    case (type_sel_e'(ctrl.ctype))
      SEL_TYPE_READ:  kind_ok = (bus_kind == KIND_READ);
      SEL_TYPE_WRITE: kind_ok = (bus_kind == KIND_WRITE);
      SEL_TYPE_DATA:  kind_ok = (bus_kind == KIND_READ) || (bus_kind == KIND_WRITE);
      default:        kind_ok = 1'b0;
    endcase
  end

  assign fetch_hit = bus_valid && !stop && (ctrl.ctype == SEL_TYPE_FETCH) &&
                     (bus_kind == KIND_FETCH) && !ctrl.msel && !bus_mst &&
                     (((bus_addr ^ brk_addr) & care) == '0);
  assign data_hit  = bus_valid && !stop && kind_ok && (bus_mst == ctrl.msel) &&
                     (((bus_addr ^ brk_addr) & care) == '0);
  assign exec_hit  = instr_start && !stop && pending_q &&
                     (((instr_addr ^ brk_addr) & care) == '0);
  assign set_flag  = data_hit || exec_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pending_q <= 1'b0;
    else if (stop)      pending_q <= 1'b0;
    else if (fetch_hit) pending_q <= 1'b1;
    else if (exec_hit)  pending_q <= 1'b0;
  end

  // R7: a fetch by itself never raises the flag
  p_fetch_deferred_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_kind == KIND_FETCH && !instr_start) |-> !set_flag);

  // R7: an instruction start with nothing pending and no data cycle sets nothing
  p_exec_needs_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_q && !bus_valid) |-> !set_flag);

  // R4: a data cycle from the unselected master is not a hit
  p_master_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_mst != ctrl.msel && !instr_start) |-> !set_flag);
endmodule

// File: rtl/brk_ctrl_top.sv
module brk_ctrl_top
  import brk_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_kind,
  input  logic              bus_mst,
  input  logic              instr_start,
  input  logic [ADDR_W-1:0] instr_addr,
  output logic              brk_irq,
  output logic              brk_flag
);
  logic [ADDR_W-1:0] brk_addr;
  brk_ctrl_t         ctrl;
  logic              flag;
  logic              stop;
  logic              set_flag;

  brk_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd), .sel(reg_sel),
    .wdata(reg_wdata), .rdata(reg_rdata), .set_flag(set_flag),
    .brk_addr(brk_addr), .ctrl(ctrl), .flag(flag), .stop(stop)
  );

  brk_match #(.ADDR_W(ADDR_W)) match_i (
    .clk(clk), .rst_n(rst_n), .stop(stop), .brk_addr(brk_addr), .ctrl(ctrl),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_kind(bus_kind),
    .bus_mst(bus_mst), .instr_start(instr_start), .instr_addr(instr_addr),
    .set_flag(set_flag)
  );

  assign brk_irq  = flag && ctrl.ie && !stop;
  assign brk_flag = flag;

  // R6: a request needs both the flag and the enable
  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |-> (brk_flag && ctrl.ie));

  // R9: a stopped block raises no request
  p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !brk_irq);

  // R9: a stopped block produces no hit
  p_stop_no_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !set_flag);
endmodule

// File: tb/brk_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module brk_ctrl_top_tb_top;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]    reg_sel = 2'd2;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic          bus_valid = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [1:0]    bus_kind = 2'd1;
  logic          bus_mst = 1'b0;
  logic          instr_start = 1'b0;
  logic [AW-1:0] instr_addr = '0;
  logic          brk_irq, brk_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  string         q_tag[$];
  bit            q_isrd[$];
  logic          q_irq[$];
  logic          q_flg[$];
  logic [AW-1:0] q_rd[$];

  always #2 clk = ~clk;

  brk_ctrl_top #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_kind(bus_kind), .bus_mst(bus_mst),
    .instr_start(instr_start), .instr_addr(instr_addr),
    .brk_irq(brk_irq), .brk_flag(brk_flag)
  );

  // monitor: pops expectations and compares against the outputs
  always @(negedge clk) begin
    if (q_tag.size() > 0) begin
      string tg;
      bit isrd;
      logic ei, ef;
      logic [AW-1:0] er;
      tg = q_tag.pop_front(); isrd = q_isrd.pop_front();
      ei = q_irq.pop_front(); ef = q_flg.pop_front(); er = q_rd.pop_front();
      checks++;
      if (isrd) begin
        if (reg_rdata !== er) begin
          errors++;
          $display("FAIL %s rdata actual %h expected %h", tg, reg_rdata, er);
        end
      end else if (brk_irq !== ei || brk_flag !== ef) begin
        errors++;
        $display("FAIL %s irq/flag actual %b/%b expected %b/%b", tg, brk_irq, brk_flag, ei, ef);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expect_st(string tg, logic ei, logic ef);
    q_tag.push_back(tg); q_isrd.push_back(1'b0);
    q_irq.push_back(ei); q_flg.push_back(ef); q_rd.push_back('0);
    @(negedge clk);
  endtask

  task automatic rreg(string tg, logic [1:0] s, logic [AW-1:0] exp);
    reg_sel = s; reg_rd = 1'b1;
    q_tag.push_back(tg); q_isrd.push_back(1'b1);
    q_irq.push_back(1'b0); q_flg.push_back(1'b0); q_rd.push_back(exp);
    @(negedge clk);
    tick();
    reg_rd = 1'b0;
  endtask

  task automatic wreg(logic [1:0] s, logic [AW-1:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic bus(logic [AW-1:0] a, logic [1:0] k, logic m);
    bus_addr = a; bus_kind = k; bus_mst = m; bus_valid = 1'b1;
    tick();
    bus_valid = 1'b0;
  endtask

  task automatic exec(logic [AW-1:0] a);
    instr_addr = a; instr_start = 1'b1;
    tick();
    instr_start = 1'b0;
  endtask

  task automatic clear_flag();
    rreg("R8 arm", 2'd2, 24'd1);
    wreg(2'd2, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R1 reset state
    expect_st("R1 reset", 0, 0);
    rreg("R1 stop", 2'd3, 24'd1);
    rreg("R1 ctrl", 2'd1, 24'd0);
    rreg("R1 addr", 2'd0, 24'd0);

    // R10 programming: ie=1, read type, no mask
    wreg(2'd0, 24'h001234);
    wreg(2'd1, 24'h21);
    rreg("R10 addr", 2'd0, 24'h001234);
    rreg("R10 ctrl", 2'd1, 24'h21);

    // R9 stopped block ignores a match
    bus(24'h001234, 2'd1, 0);
    expect_st("R9 stopped", 0, 0);
    wreg(2'd0, 24'h001234);
    rreg("R9 kept", 2'd1, 24'h21);

    wreg(2'd3, '0);
    bus(24'h001235, 2'd1, 0);
    expect_st("R5 no mask", 0, 0);
    bus(24'h001234, 2'd2, 0);
    expect_st("R3 write vs read sel", 0, 0);
    bus(24'h001234, 2'd0, 0);
    expect_st("R3 fetch vs read sel", 0, 0);
    bus(24'h001234, 2'd1, 1);
    expect_st("R4 wrong master", 0, 0);
    bus(24'h001234, 2'd1, 0);
    expect_st("R2 read hit", 1, 1);

    // R8 clear without prior read has no effect
    wreg(2'd2, '0);
    expect_st("R8 unarmed clear", 1, 1);
    clear_flag();
    expect_st("R8 clear", 0, 0);

    // R6 ie=0, type 11, mask code 5 (8 bits)
    wreg(2'd1, 24'h74);
    bus(24'h0012FF, 2'd2, 0);
    expect_st("R6 flag without irq", 0, 1);
    // R8 clear races a match
    rreg("R8 arm race", 2'd2, 24'd1);
    reg_sel = 2'd2; reg_wdata = '0; reg_wr = 1'b1;
    bus_addr = 24'h001200; bus_kind = 2'd1; bus_mst = 0; bus_valid = 1'b1;
    tick();
    reg_wr = 1'b0; bus_valid = 1'b0;
    expect_st("R8 match wins", 0, 1);
    clear_flag();
    expect_st("R8 clear after race", 0, 0);
    bus(24'h001334, 2'd1, 0);
    expect_st("R5 bit8 compared", 0, 0);

    // R5 mask code 7 (16 bits)
    wreg(2'd1, 24'h7C);
    bus(24'h011234, 2'd1, 0);
    expect_st("R5 bit16 compared", 0, 0);
    bus(24'h00ABCD, 2'd2, 0);
    expect_st("R5 16 bits ignored", 0, 1);
    clear_flag();

    // R5 mask code 2 (2 bits), ie=1, read type
    wreg(2'd1, 24'h29);
    bus(24'h001237, 2'd1, 0);
    expect_st("R5 two bits ignored", 1, 1);
    clear_flag();
    bus(24'h001238, 2'd1, 0);
    expect_st("R5 bit3 compared", 0, 0);

    // R4 other master selected
    wreg(2'd1, 24'h23);
    bus(24'h001234, 2'd1, 0);
    expect_st("R4 cpu vs other sel", 0, 0);
    bus(24'h001234, 2'd1, 1);
    expect_st("R4 other master hit", 1, 1);
    clear_flag();

    // R7 fetch break
    wreg(2'd1, 24'h01);
    exec(24'h001234);
    expect_st("R7 start w/o fetch", 0, 0);
    bus(24'h001234, 2'd0, 0);
    expect_st("R7 fetch deferred", 0, 0);
    exec(24'h001234);
    expect_st("R7 reported at start", 1, 1);
    clear_flag();
    wreg(2'd1, 24'h03);
    bus(24'h001234, 2'd0, 1);
    exec(24'h001234);
    expect_st("R7 msel1 never fires", 0, 0);

    // R9 stop while flag set
    wreg(2'd1, 24'h01);
    bus(24'h001234, 2'd0, 0);
    exec(24'h001234);
    expect_st("R7 second hit", 1, 1);
    wreg(2'd3, 24'd1);
    expect_st("R9 irq held low", 0, 1);
    rreg("R9 addr kept", 2'd0, 24'h001234);

    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule